// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer

This block turns a 32-bit virtual byte address into a 32-bit physical byte address. It looks the address up in a small direct-mapped buffer of recent page translations. Pages are 4 KB. The low 12 address bits are the byte offset inside the page and are carried to the physical address unchanged. The upper 20 bits form the virtual page number. The low 4 bits of that page number choose one of 16 entries. The remaining 16 bits are compared against the tag stored in that entry.

The lookup side is combinational from the stored entries. It reports a hit, the physical address, and the two page flags (dirty and writable). It raises a fault when a store hits a page that is not writable.

A separate fill port writes a translation into the entry that its page number selects. The fill takes effect on the clock edge. A single invalidate-all input empties the whole buffer in one cycle. On a miss the block only reports the miss; fetching the translation belongs to the surrounding logic.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset, every entry is empty, so every lookup reports `lk_hit` = 0.
- R2: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]` for every offset value.
- R3: Entry index is `lk_vaddr[15:12]` and the compared tag is `lk_vaddr[31:16]`. A hit needs the indexed entry to be valid with an equal tag, and then `lk_paddr[31:12]` is that entry's stored frame number.
- R4: A lookup whose index matches a valid entry but whose tag differs reports a miss.
- R5: A fill writes on the clock edge. A lookup of the same page in the same cycle as the fill still misses, and the lookup hits from the next cycle on.
- R6: A fill to an index that already holds a valid entry replaces it. The old page then misses and the new one hits.
- R7: On a hit, `lk_dirty` and `lk_writable` equal the flag values given with the fill.
- R8: `lk_fault` is 1 exactly when `lk_write` = 1, the lookup hits, and the entry's writable flag is 0. A read lookup or a missing lookup never faults.
- R9: One cycle with `inval_all` = 1 empties all 16 entries; every lookup afterwards misses until refilled.
- R10: When `inval_all` and `fill_en` are both high in the same cycle, the invalidate wins and the filled page is absent afterwards.
- R11: The 16 entries are independent. Filling one index leaves the translations at all other indices intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual byte address to translate |
| lk_write | input | 1 | Lookup is a store access |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Physical byte address, meaningful on hit |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| lk_writable | output | 1 | Writable flag of the hit entry |
| lk_fault | output | 1 | Store to a non-writable page |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number of the translation |
| fill_ppn | input | 20 | Physical frame number of the translation |
| fill_dirty | input | 1 | Dirty flag to store |
| fill_writable | input | 1 | Writable flag to store |
| inval_all | input | 1 | Empty the entire buffer |

## Verification
All 16 indices are filled with tags and frame numbers computed from the index. Each one is then looked up with offsets of all zeros, all ones, and an index-dependent pattern. These lookups separate index decoding, tag comparison and offset pass-through from one another. Each page is looked up as a read and as a store, with the flag bits varied across indices, which shows whether the fault follows the writable flag alone. Lookups that use the right index with a different tag, a same-cycle lookup during a fill, an overwrite of one index, and an invalidate that collides with a fill cover aliasing, write timing, replacement and clear priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_BITS   = 32;
  localparam int unsigned PA_BITS   = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned SET_BITS  = 4;

  typedef struct packed {
    logic dirty;
    logic writable;
  } tlb_flags_t;

  localparam int unsigned FLAG_BITS = $bits(tlb_flags_t);
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int unsigned SET_W = SET_BITS,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [SET_W-1:0] w_set,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [PPN_W-1:0] w_ppn,
  input  tlb_flags_t       w_flags,
  input  logic [SET_W-1:0] r_set,
  output logic             r_valid,
  output logic [TAG_W-1:0] r_tag,
  output logic [PPN_W-1:0] r_ppn,
  output tlb_flags_t       r_flags
);
  localparam int unsigned DEPTH  = 1 << SET_W;
  localparam int unsigned DATA_W = FLAG_BITS + PPN_W + TAG_W;

  // Payload array carries no reset so it can map onto RAM resources.
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (we && !clr) begin
      mem_q[w_set] <= {w_flags, w_ppn, w_tag};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[w_set] <= 1'b1;
    end
  end

  always_comb begin
    rd_word = mem_q[r_set];
    r_valid = valid_q[r_set];
    r_tag   = rd_word[TAG_W-1:0];
    r_ppn   = rd_word[TAG_W +: PPN_W];
    r_flags = tlb_flags_t'(rd_word[DATA_W-1 -: FLAG_BITS]);
  end

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid_q == '0));

  // R10
  clear_beats_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && we) |=> !valid_q[$past(w_set)]);

  // R5
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> valid_q[$past(w_set)]);
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W  = VA_BITS,
  parameter int unsigned PA_W  = PA_BITS,
  parameter int unsigned OFF_W = PAGE_BITS,
  parameter int unsigned SET_W = SET_BITS
) (
  input  logic [VA_W-1:0]        vaddr,
  input  logic                   is_write,
  output logic [SET_W-1:0]       set_idx,
  input  logic                   e_valid,
  input  logic [VA_W-OFF_W-SET_W-1:0] e_tag,
  input  logic [PA_W-OFF_W-1:0]  e_ppn,
  input  tlb_flags_t             e_flags,
  output logic                   hit,
  output logic [PA_W-1:0]        paddr,
  output logic                   dirty,
  output logic                   writable,
  output logic                   fault
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned TAG_W = VPN_W - SET_W;

  logic [TAG_W-1:0] probe_tag;
  logic             tag_eq;

  always_comb begin
    set_idx   = vaddr[OFF_W +: SET_W];
    probe_tag = vaddr[VA_W-1 -: TAG_W];
    tag_eq    = (probe_tag == e_tag);
    hit       = e_valid && tag_eq;
    paddr     = {e_ppn, vaddr[OFF_W-1:0]};
    dirty     = e_flags.dirty;
    writable  = e_flags.writable;
    fault     = hit && is_write && !e_flags.writable;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W  = VA_BITS,
  parameter int unsigned PA_W  = PA_BITS,
  parameter int unsigned OFF_W = PAGE_BITS,
  parameter int unsigned SET_W = SET_BITS,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_dirty,
  output logic             lk_writable,
  output logic             lk_fault,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             fill_writable,
  input  logic             inval_all
);
  localparam int unsigned TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] rd_set;
  logic             e_valid;
  logic [TAG_W-1:0] e_tag;
  logic [PPN_W-1:0] e_ppn;
  tlb_flags_t       e_flags;
  tlb_flags_t       w_flags;

  assign w_flags = '{dirty: fill_dirty, writable: fill_writable};

  tlb_entry_store #(
    .SET_W(SET_W),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) store_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (inval_all),
    .we     (fill_en),
    .w_set  (fill_vpn[SET_W-1:0]),
    .w_tag  (fill_vpn[VPN_W-1 -: TAG_W]),
    .w_ppn  (fill_ppn),
    .w_flags(w_flags),
    .r_set  (rd_set),
    .r_valid(e_valid),
    .r_tag  (e_tag),
    .r_ppn  (e_ppn),
    .r_flags(e_flags)
  );

  tlb_lookup #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFF_W(OFF_W),
    .SET_W(SET_W)
  ) lookup_i (
    .vaddr   (lk_vaddr),
    .is_write(lk_write),
    .set_idx (rd_set),
    .e_valid (e_valid),
    .e_tag   (e_tag),
    .e_ppn   (e_ppn),
    .e_flags (e_flags),
    .hit     (lk_hit),
    .paddr   (lk_paddr),
    .dirty   (lk_dirty),
    .writable(lk_writable),
    .fault   (lk_fault)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inval_all) |=>
      ((lk_vaddr[VA_W-1:OFF_W] != $past(fill_vpn)) ||
       (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn))));

  // R8
  fault_needs_store_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_hit && lk_write && !lk_writable));

  // R9
  inval_miss_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> !lk_hit);
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_vaddr;
  logic        lk_write;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        lk_dirty;
  logic        lk_writable;
  logic        lk_fault;
  logic        fill_en;
  logic [19:0] fill_vpn;
  logic [19:0] fill_ppn;
  logic        fill_dirty;
  logic        fill_writable;
  logic        inval_all;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .lk_writable(lk_writable), .lk_fault(lk_fault), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .fill_writable(fill_writable), .inval_all(inval_all)
  );

  function automatic logic [15:0] tag_of(int i);
    return 16'hC000 + 16'(i * 3);
  endfunction
  function automatic logic [19:0] ppn_of(int i);
    return 20'h80000 ^ 20'(i * 20'h01111);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_fill(logic [19:0] vpn, logic [19:0] ppn, logic d, logic w);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_dirty = d; fill_writable = w;
    tick();
    fill_en = 1'b0;
  endtask

  task automatic probe(logic [31:0] va, logic wr);
    lk_vaddr = va; lk_write = wr;
    #1;
  endtask

  task automatic expect_miss(logic [31:0] va, string req);
    probe(va, 1'b0);
    check(lk_hit == 1'b0, req, lk_hit, 0);
    probe(va, 1'b1);
    check(lk_fault == 1'b0, "R8 miss no fault", lk_fault, 0);
  endtask

  task automatic expect_hit(int i, logic [15:0] tg, logic [19:0] pp, logic [11:0] off);
    logic [31:0] va;
    va = {tg, 4'(i), off};
    probe(va, 1'b0);
    check(lk_hit == 1'b1, "R3 hit", lk_hit, 1);
    check(lk_paddr[31:12] == pp, "R3 frame", lk_paddr, {pp, off});
    check(lk_paddr[11:0] == off, "R2 offset", lk_paddr[11:0], off);
    check(lk_dirty == i[0], "R7 dirty", lk_dirty, i[0]);
    check(lk_writable == i[1], "R7 writable", lk_writable, i[1]);
    check(lk_fault == 1'b0, "R8 read no fault", lk_fault, 0);
    probe(va, 1'b1);
    check(lk_fault == !i[1], "R8 store fault", lk_fault, !i[1]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lk_vaddr = '0; lk_write = 1'b0; fill_en = 1'b0;
    fill_vpn = '0; fill_ppn = '0; fill_dirty = 1'b0; fill_writable = 1'b0;
    inval_all = 1'b0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;

    // R1: empty after reset
    for (int i = 0; i < 16; i++) expect_miss({tag_of(i), 4'(i), 12'h000}, "R1 reset empty");

    // R5: same-cycle lookup misses, next cycle hits
    fill_en = 1'b1; fill_vpn = {tag_of(0), 4'd0}; fill_ppn = ppn_of(0);
    fill_dirty = 1'b0; fill_writable = 1'b0;
    probe({tag_of(0), 4'd0, 12'h123}, 1'b0);
    check(lk_hit == 1'b0, "R5 same cycle miss", lk_hit, 0);
    tick();
    fill_en = 1'b0;
    probe({tag_of(0), 4'd0, 12'h123}, 1'b0);
    check(lk_hit == 1'b1, "R5 next cycle hit", lk_hit, 1);

    // R11: fill all sets, then check each with three offsets
    for (int i = 1; i < 16; i++) do_fill({tag_of(i), 4'(i)}, ppn_of(i), i[0], i[1]);
    for (int i = 0; i < 16; i++) begin
      expect_hit(i, tag_of(i), ppn_of(i), 12'h000);
      expect_hit(i, tag_of(i), ppn_of(i), 12'hFFF);
      expect_hit(i, tag_of(i), ppn_of(i), 12'(i * 12'h111));
      // R4: same set, different tag
      expect_miss({tag_of(i) ^ 16'h0100, 4'(i), 12'h040}, "R4 alias miss");
    end

    // R6: overwrite set 5; R11 others unchanged
    do_fill({16'h5A5A, 4'd5}, 20'h0BEEF, 1'b1, 1'b0);
    expect_miss({tag_of(5), 4'd5, 12'h010}, "R6 old page gone");
    expect_hit(5, 16'h5A5A, 20'h0BEEF, 12'h7AB);
    for (int i = 0; i < 16; i++)
      if (i != 5) expect_hit(i, tag_of(i), ppn_of(i), 12'h3C3);

    // R10: invalidate collides with fill; R9 everything empty
    fill_en = 1'b1; fill_vpn = {16'h7777, 4'd7}; fill_ppn = 20'h12345;
    fill_dirty = 1'b0; fill_writable = 1'b1; inval_all = 1'b1;
    tick();
    fill_en = 1'b0; inval_all = 1'b0;
    expect_miss({16'h7777, 4'd7, 12'h000}, "R10 inval beats fill");
    for (int i = 0; i < 16; i++) expect_miss({tag_of(i), 4'(i), 12'h000}, "R9 all empty");

    // refill after invalidate
    do_fill({tag_of(3), 4'd3}, ppn_of(3), 1'b1, 1'b1);
    expect_hit(3, tag_of(3), ppn_of(3), 12'hABC);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule